// File: doc/BRIEF.md
# One-Time-Programmable Fuse Read Controller

This block fronts a small array of 32-bit fuse words whose bits can only be set, never cleared. Software drives it over a simple 32-bit register bus (write strobe, read strobe, byte address, registered read data one cycle after the read strobe). It chooses a word through the address field of the control register and starts an access by writing the read-trigger register. For a program operation, software first loads a 16-bit unlock key into the control register, then writes the program-data register.

Every access is timed by cycle counts that software writes into the timing register. There is a lead relax phase, then a strobe phase whose length depends on whether the access is a read or a program, then a trailing relax phase. BUSY is high for the whole sequence. An access that starts while BUSY is high, or that names a word outside the array, raises a sticky error flag. A rejected read also leaves a fixed poison word in the read-data register. A completed program ORs the data into the word and drops the unlock key.

Top module: `otp_fuse_ctrl`

## Requirements
- R1: After reset, the control, timing, program-data and read-data registers all read as zero, and every fuse word holds zero.
- R2: The control register has these fields: address in bits 6:0, BUSY in bit 8, ERR in bit 9, reload flag in bit 10 and unlock field in bits 31:16. It is visible at offsets 0x00, 0x04 and 0x08. A write to 0x00 replaces the writable fields. A write to 0x04 ORs the written value into them. A write to 0x08 clears each bit that is written as 1. BUSY cannot be written.
- R3: The timing register at 0x10 keeps only three fields: read strobe in bits 21:16, relax in bits 15:12 and program strobe in bits 11:0. All other bits read back as zero.
- R4: Writing a word with bit 0 set to the trigger register at 0x30 starts a read of the addressed word. BUSY then reads as 1 for exactly 2*(relax+1)+(read_strobe+1) cycles. When BUSY drops, the read-data register at 0x40 holds the fuse word.
- R5: A write to the program-data register at 0x20 while the unlock field holds 0x3E77 starts a program operation. BUSY then reads as 1 for 2*(relax+1)+(program_strobe+1) cycles. At the end, the addressed word becomes its old value ORed with the written data, and the unlock field returns to zero.
- R6: A write to the program-data register while the unlock field does not hold 0x3E77 leaves the array unchanged, does not raise BUSY and does not set ERR.
- R7: A read or a keyed program requested while BUSY is high sets ERR. A read requested in this way loads 0xBADABADA into the read-data register at once. The operation in progress still completes with its own result.
- R8: A read or a keyed program that addresses a word at or beyond the array size sets ERR and does not raise BUSY. A read in this case loads 0xBADABADA into the read-data register.
- R9: ERR stays set until software writes 1 to bit 9 at offset 0x08, or writes offset 0x00.
- R10: Changes to the address, timing or unlock fields while BUSY is high do not alter the length, the address or the data of the operation in progress.
- R11: A write to the trigger register with bit 0 clear starts nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 8 | Register byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after bus_rd |

## Verification
If the phase counter or its latched copy of the timing is wrong, the number of cycles for which BUSY reads high after a trigger changes. Polling the control register every cycle therefore shows the error within one access. A wrong latched address or a wrong merge of the program data shows up at the very next read of that word, as an unexpected value in the read-data register. A lost or stray error update shows in bit 9 on the next control read. A poison load that is missing, or that arrives late, is visible in the read-data register one cycle after the rejected request.

// File: rtl/otp_fuse_pkg.sv
package otp_fuse_pkg;
  localparam int DATA_W     = 32;
  localparam int FADDR_W    = 7;
  localparam int UNLOCK_W   = 16;
  localparam int TIMING_W   = 22;

  localparam logic [7:0] OFF_CTRL  = 8'h00;
  localparam logic [7:0] OFF_SET   = 8'h04;
  localparam logic [7:0] OFF_CLR   = 8'h08;
  localparam logic [7:0] OFF_TIME  = 8'h10;
  localparam logic [7:0] OFF_PDATA = 8'h20;
  localparam logic [7:0] OFF_TRIG  = 8'h30;
  localparam logic [7:0] OFF_RDATA = 8'h40;

  localparam int BIT_BUSY   = 8;
  localparam int BIT_ERR    = 9;
  localparam int BIT_RELOAD = 10;
  localparam int LSB_UNLOCK = 16;

  localparam logic [UNLOCK_W-1:0] UNLOCK_KEY  = 16'h3E77;
  localparam logic [DATA_W-1:0]   POISON_WORD = 32'hBADA_BADA;

  typedef struct packed {
    logic [5:0]  strobe_rd;
    logic [3:0]  relax;
    logic [11:0] strobe_pg;
  } timing_t;

  typedef enum logic [1:0] {
    PH_IDLE,
    PH_LEAD,
    PH_STROBE,
    PH_TAIL
  } phase_t;
endpackage

// File: rtl/otp_fuse_array.sv
module otp_fuse_array #(
  parameter int WORDS  = 64,
  parameter int DATA_W = 32,
  localparam int AW    = $clog2(WORDS)
) (
  input  logic              clk,
  input  logic [AW-1:0]     rd_addr,
  input  logic              wr_en,
  input  logic [AW-1:0]     wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_q
);
  logic [DATA_W-1:0] mem [WORDS];

  initial begin
    for (int i = 0; i < WORDS; i++) mem[i] = '0;
  end

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
    rd_q <= mem[rd_addr];
  end
endmodule

// File: rtl/otp_fuse_seq.sv
module otp_fuse_seq
  import otp_fuse_pkg::*;
#(
  parameter int WORDS  = 64,
  localparam int AW    = $clog2(WORDS),
  localparam int CNT_W = 12
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               req_rd,
  input  logic               req_pg,
  input  logic [FADDR_W-1:0] req_addr,
  input  timing_t            timing,
  input  logic [DATA_W-1:0]  pg_data,
  output logic               busy,
  output logic               reject,
  output logic               done_rd,
  output logic               done_pg,
  output logic               mem_we,
  output logic [DATA_W-1:0]  rd_word
);
  phase_t            phase_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              op_pg_q;
  logic [AW-1:0]     op_addr_q;
  timing_t           op_tim_q;
  logic [DATA_W-1:0] op_data_q;
  logic [DATA_W-1:0] mem_q;
  logic              addr_ok, any_req, accept, last;

  assign addr_ok = ({1'b0, req_addr} < 8'(WORDS));
  assign any_req = req_rd | req_pg;
  assign busy    = (phase_q != PH_IDLE);
  assign reject  = any_req & (busy | ~addr_ok);
  assign accept  = any_req & ~reject;
  assign last    = (cnt_q == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q   <= PH_IDLE;
      cnt_q     <= '0;
      op_pg_q   <= 1'b0;
      op_addr_q <= '0;
      op_tim_q  <= '0;
      op_data_q <= '0;
    end else begin
      case (phase_q)
        PH_IDLE: if (accept) begin
          phase_q   <= PH_LEAD;
          cnt_q     <= CNT_W'(timing.relax);
          op_pg_q   <= req_pg;
          op_addr_q <= req_addr[AW-1:0];
          op_tim_q  <= timing;
          op_data_q <= pg_data;
        end
        PH_LEAD: if (last) begin
          phase_q <= PH_STROBE;
          cnt_q   <= op_pg_q ? op_tim_q.strobe_pg : CNT_W'(op_tim_q.strobe_rd);
        end else cnt_q <= cnt_q - 1'b1;
        PH_STROBE: if (last) begin
          phase_q <= PH_TAIL;
          cnt_q   <= CNT_W'(op_tim_q.relax);
        end else cnt_q <= cnt_q - 1'b1;
        default: if (last) phase_q <= PH_IDLE;
                 else cnt_q <= cnt_q - 1'b1;
      endcase
    end
  end

  assign done_rd = (phase_q == PH_TAIL) & last & ~op_pg_q;
  assign done_pg = (phase_q == PH_TAIL) & last & op_pg_q;
  assign mem_we  = done_pg;
  assign rd_word = mem_q;

  otp_fuse_array #(.WORDS(WORDS), .DATA_W(DATA_W)) i_array (
    .clk     (clk),
    .rd_addr (op_addr_q),
    .wr_en   (mem_we),
    .wr_addr (op_addr_q),
    .wr_data (mem_q | op_data_q),
    .rd_q    (mem_q)
  );
endmodule

// File: rtl/otp_fuse_regs.sv
module otp_fuse_regs
  import otp_fuse_pkg::*;
(
  input  logic                clk,
  input  logic                rst,
  input  logic                bus_wr,
  input  logic                bus_rd,
  input  logic [7:0]          bus_addr,
  input  logic [DATA_W-1:0]   bus_wdata,
  output logic [DATA_W-1:0]   bus_rdata,
  input  logic                busy,
  input  logic                reject,
  input  logic                done_rd,
  input  logic                done_pg,
  input  logic [DATA_W-1:0]   rd_word,
  output logic                req_rd,
  output logic                req_pg,
  output logic [FADDR_W-1:0]  fuse_addr,
  output timing_t             timing,
  output logic                err,
  output logic [UNLOCK_W-1:0] unlock
);
  logic [FADDR_W-1:0]  addr_q, addr_d;
  logic                err_q, err_d, reload_q, reload_d;
  logic [UNLOCK_W-1:0] unlock_q, unlock_d;
  timing_t             timing_q;
  logic [DATA_W-1:0]   pdata_q, rdata_q, rdbus_q, ctrl_word;
  logic                wr_base, wr_set, wr_clr;

  assign wr_base = bus_wr & (bus_addr == OFF_CTRL);
  assign wr_set  = bus_wr & (bus_addr == OFF_SET);
  assign wr_clr  = bus_wr & (bus_addr == OFF_CLR);
  assign req_rd  = bus_wr & (bus_addr == OFF_TRIG) & bus_wdata[0];
  assign req_pg  = bus_wr & (bus_addr == OFF_PDATA) & (unlock_q == UNLOCK_KEY);

  assign ctrl_word = {unlock_q, 5'b0, reload_q, err_q, busy, 1'b0, addr_q};

  always_comb begin
    addr_d   = addr_q;
    err_d    = err_q;
    reload_d = reload_q;
    unlock_d = unlock_q;
    if (wr_base) begin
      addr_d   = bus_wdata[FADDR_W-1:0];
      err_d    = bus_wdata[BIT_ERR];
      reload_d = bus_wdata[BIT_RELOAD];
      unlock_d = bus_wdata[LSB_UNLOCK +: UNLOCK_W];
    end else if (wr_set) begin
      addr_d   = addr_q   | bus_wdata[FADDR_W-1:0];
      err_d    = err_q    | bus_wdata[BIT_ERR];
      reload_d = reload_q | bus_wdata[BIT_RELOAD];
      unlock_d = unlock_q | bus_wdata[LSB_UNLOCK +: UNLOCK_W];
    end else if (wr_clr) begin
      addr_d   = addr_q   & ~bus_wdata[FADDR_W-1:0];
      err_d    = err_q    & ~bus_wdata[BIT_ERR];
      reload_d = reload_q & ~bus_wdata[BIT_RELOAD];
      unlock_d = unlock_q & ~bus_wdata[LSB_UNLOCK +: UNLOCK_W];
    end
    if (reject)  err_d    = 1'b1;
    if (done_pg) unlock_d = '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q   <= '0;
      err_q    <= 1'b0;
      reload_q <= 1'b0;
      unlock_q <= '0;
      timing_q <= '0;
      pdata_q  <= '0;
      rdata_q  <= '0;
      rdbus_q  <= '0;
    end else begin
      addr_q   <= addr_d;
      err_q    <= err_d;
      reload_q <= reload_d;
      unlock_q <= unlock_d;
      if (bus_wr && bus_addr == OFF_TIME)  timing_q <= bus_wdata[TIMING_W-1:0];
      if (bus_wr && bus_addr == OFF_PDATA) pdata_q  <= bus_wdata;
      if (done_rd)               rdata_q <= rd_word;
      if (reject && req_rd)      rdata_q <= POISON_WORD;
      if (bus_rd) begin
        case (bus_addr)
          OFF_CTRL, OFF_SET, OFF_CLR: rdbus_q <= ctrl_word;
          OFF_TIME:  rdbus_q <= {{(DATA_W-TIMING_W){1'b0}}, timing_q};
          OFF_PDATA: rdbus_q <= pdata_q;
          OFF_RDATA: rdbus_q <= rdata_q;
          default:   rdbus_q <= '0;
        endcase
      end
    end
  end

  assign bus_rdata = rdbus_q;
  assign fuse_addr = addr_q;
  assign timing    = timing_q;
  assign err       = err_q;
  assign unlock    = unlock_q;
endmodule

// File: rtl/otp_fuse_ctrl.sv
module otp_fuse_ctrl
  import otp_fuse_pkg::*;
#(
  parameter int WORDS = 64
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        bus_wr,
  input  logic        bus_rd,
  input  logic [7:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata
);
  logic                seq_busy, seq_reject, seq_done_rd, seq_done_pg, seq_mem_we;
  logic [DATA_W-1:0]   seq_rd_word;
  logic                req_rd, req_pg;
  logic [FADDR_W-1:0]  fuse_addr;
  timing_t             timing;
  logic                ctrl_err;
  logic [UNLOCK_W-1:0] ctrl_unlock;

  otp_fuse_regs i_regs (
    .clk       (clk),
    .rst       (rst),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .busy      (seq_busy),
    .reject    (seq_reject),
    .done_rd   (seq_done_rd),
    .done_pg   (seq_done_pg),
    .rd_word   (seq_rd_word),
    .req_rd    (req_rd),
    .req_pg    (req_pg),
    .fuse_addr (fuse_addr),
    .timing    (timing),
    .err       (ctrl_err),
    .unlock    (ctrl_unlock)
  );

  otp_fuse_seq #(.WORDS(WORDS)) i_seq (
    .clk      (clk),
    .rst      (rst),
    .req_rd   (req_rd),
    .req_pg   (req_pg),
    .req_addr (fuse_addr),
    .timing   (timing),
    .pg_data  (bus_wdata),
    .busy     (seq_busy),
    .reject   (seq_reject),
    .done_rd  (seq_done_rd),
    .done_pg  (seq_done_pg),
    .mem_we   (seq_mem_we),
    .rd_word  (seq_rd_word)
  );
endmodule

// File: rtl/otp_fuse_chk.sv
module otp_fuse_chk
  import otp_fuse_pkg::*;
#(
  parameter int WORDS = 64
) (
  input logic                clk,
  input logic                rst,
  input logic                busy,
  input logic                reject,
  input logic                req_rd,
  input logic                req_pg,
  input logic                done_pg,
  input logic                mem_we,
  input logic                err,
  input logic [UNLOCK_W-1:0] unlock,
  input logic [FADDR_W-1:0]  fuse_addr,
  input logic                bus_wr,
  input logic [7:0]          bus_addr,
  input logic [31:0]         bus_wdata
);
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
    err && !(bus_wr && bus_addr == OFF_CTRL)
        && !(bus_wr && bus_addr == OFF_CLR && bus_wdata[BIT_ERR]) |=> err); // R9

  AST_UNLOCK_DROPPED: assert property (@(posedge clk) disable iff (rst)
    done_pg |=> (unlock == '0)); // R5

  AST_WRITE_NEEDS_BUSY: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> busy); // R6

  AST_BAD_ADDR_REJECT: assert property (@(posedge clk) disable iff (rst)
    (req_rd || req_pg) && ({1'b0, fuse_addr} >= 8'(WORDS)) |-> reject); // R8

  AST_REJECT_SETS_ERR: assert property (@(posedge clk) disable iff (rst)
    reject |=> err); // R7

  AST_BUSY_FROM_REQUEST: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(req_rd || req_pg)); // R4
endmodule

bind otp_fuse_ctrl otp_fuse_chk #(.WORDS(WORDS)) i_chk (
  .clk       (clk),
  .rst       (rst),
  .busy      (seq_busy),
  .reject    (seq_reject),
  .req_rd    (req_rd),
  .req_pg    (req_pg),
  .done_pg   (seq_done_pg),
  .mem_we    (seq_mem_we),
  .err       (ctrl_err),
  .unlock    (ctrl_unlock),
  .fuse_addr (fuse_addr),
  .bus_wr    (bus_wr),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata)
);

// File: tb/test_otp_fuse_ctrl.sv
module test_otp_fuse_ctrl;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  int total = 0;
  int bad = 0;
  int cycles = 0;

  localparam logic [31:0] KEYF = 32'h3E77_0000;
  localparam logic [31:0] POISON = 32'hBADA_BADA;

  always #10 clk = ~clk;

  otp_fuse_ctrl #(.WORDS(64)) i_otp_fuse_ctrl (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 100000) begin
      total = total + 1;
      bad = bad + 1;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic poll(output int n);
    logic [31:0] v;
    n = 0;
    for (int i = 0; i < 5000; i++) begin
      rd(8'h00, v);
      if (!v[8]) break;
      n++;
    end
  endtask

  task automatic fuse_read(input logic [6:0] a, output logic [31:0] d, output int n);
    wr(8'h00, {25'b0, a});
    wr(8'h30, 32'h1);
    poll(n);
    rd(8'h40, d);
  endtask

  task automatic t_reset;
    logic [31:0] v;
    rd(8'h00, v); chk("R1 ctrl", v, 32'h0);
    rd(8'h10, v); chk("R1 timing", v, 32'h0);
    rd(8'h40, v); chk("R1 rdata", v, 32'h0);
  endtask

  task automatic t_ctrl_alias;
    logic [31:0] v;
    wr(8'h00, 32'h0000_0405); rd(8'h00, v); chk("R2 base write", v, 32'h0000_0405);
    wr(8'h04, 32'h0000_0030); rd(8'h04, v); chk("R2 set alias", v, 32'h0000_0435);
    wr(8'h08, 32'h0000_0401); rd(8'h08, v); chk("R2 clear alias", v, 32'h0000_0034);
    wr(8'h00, 32'h0000_0100); rd(8'h00, v); chk("R2 busy not writable", v, 32'h0);
  endtask

  task automatic t_timing_mask;
    logic [31:0] v;
    wr(8'h10, 32'hFFFF_FFFF); rd(8'h10, v); chk("R3 timing mask", v, 32'h003F_FFFF);
  endtask

  task automatic t_trigger_zero;
    logic [31:0] v;
    wr(8'h10, 32'h0001_1000);
    wr(8'h30, 32'h2);
    rd(8'h00, v); chk("R11 no busy", v, 32'h0);
    rd(8'h40, v); chk("R11 rdata kept", v, 32'h0);
  endtask

  task automatic t_program_key;
    logic [31:0] v; int n;
    wr(8'h10, 32'h0003_2005);
    wr(8'h00, KEYF | 32'h5);
    wr(8'h20, 32'hA5A5_0000);
    poll(n); chk("R5 program busy cycles", 32'(n), 32'd12);
    rd(8'h00, v); chk("R5 unlock cleared", v, 32'h0000_0005);
    fuse_read(7'd5, v, n);
    chk("R4 read busy cycles", 32'(n), 32'd10);
    chk("R4 read data", v, 32'hA5A5_0000);
    wr(8'h00, KEYF | 32'h5);
    wr(8'h20, 32'h0000_00F0);
    poll(n);
    fuse_read(7'd5, v, n); chk("R5 OR merge", v, 32'hA5A5_00F0);
  endtask

  task automatic t_program_nokey;
    logic [31:0] v; int n;
    wr(8'h00, 32'h0000_0005);
    wr(8'h20, 32'hFFFF_FFFF);
    rd(8'h00, v); chk("R6 no busy no err", v, 32'h0000_0005);
    fuse_read(7'd5, v, n); chk("R6 array unchanged", v, 32'hA5A5_00F0);
  endtask

  task automatic t_read_fast;
    logic [31:0] v; int n;
    wr(8'h10, 32'h0);
    fuse_read(7'd5, v, n);
    chk("R4 minimum busy cycles", 32'(n), 32'd3);
    chk("R4 fast read data", v, 32'hA5A5_00F0);
    fuse_read(7'd0, v, n); chk("R4 word 0", v, 32'h0);
  endtask

  task automatic t_bad_addr;
    logic [31:0] v;
    wr(8'h00, 32'h0000_0040);
    wr(8'h30, 32'h1);
    rd(8'h00, v); chk("R8 read err no busy", v, 32'h0000_0240);
    rd(8'h40, v); chk("R8 poison", v, POISON);
    wr(8'h08, 32'h0000_0200);
    wr(8'h00, KEYF | 32'h40);
    wr(8'h20, 32'h1);
    rd(8'h00, v); chk("R8 program err no busy", v, KEYF | 32'h240);
    wr(8'h00, 32'h0);
  endtask

  task automatic t_err_sticky;
    logic [31:0] v;
    wr(8'h00, 32'h0000_0041);
    wr(8'h30, 32'h1);
    wr(8'h04, 32'h0);
    wr(8'h08, 32'h0000_0001);
    rd(8'h00, v); chk("R9 err sticky", v, 32'h0000_0240);
    wr(8'h08, 32'h0000_0200);
    rd(8'h00, v); chk("R9 err cleared", v, 32'h0000_0040);
  endtask

  task automatic t_busy_conflict;
    logic [31:0] v; int n;
    wr(8'h10, 32'h0003_3000);
    wr(8'h00, 32'h0000_0005);
    wr(8'h30, 32'h1);
    wr(8'h00, 32'h0000_0000);
    wr(8'h10, 32'h0000_0000);
    wr(8'h30, 32'h1);
    rd(8'h40, v); chk("R7 poison while busy", v, POISON);
    poll(n); chk("R10 length kept", 32'(n), 32'd8);
    rd(8'h40, v); chk("R10 R7 address and result kept", v, 32'hA5A5_00F0);
    rd(8'h00, v); chk("R7 err set", v, 32'h0000_0200);
    wr(8'h08, 32'h0000_0200);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_ctrl_alias();
    t_timing_mask();
    t_trigger_zero();
    t_program_key();
    t_program_nokey();
    t_read_fast();
    t_bad_addr();
    t_err_sticky();
    t_busy_conflict();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule